// File: doc/BRIEF.md
# I2C Slave Address and General-Call Recognizer

This block watches the bytes that the serial shifter hands over while the interface acts as a receiving slave. It compares only the byte that directly follows a START or repeated START. Two sticky flags come out of that comparison. `addr_hit` means the byte selected this device. `gcall` means the byte was the all-zero general-call address. The block also keeps the read/write bit of that byte in a register, so the surrounding controller can pick the direction of the transfer.

Two addressing widths are supported. With 7-bit addressing, only the upper seven bits are compared, and a general call also counts as a hit. With 10-bit addressing, the whole first byte must equal the whole own-address register, including the read/write position.

The two flags are released by different events. `gcall` falls on any START or STOP. `addr_hit` falls only when the CPU writes to the data shift register. The controller must handle the second address byte of 10-bit mode, acknowledge generation and bit shifting itself.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `addr_hit`, `gcall` and `rw_bit` are all 0.
- R2: With `ten_bit`=0, an address byte sets `addr_hit` when its bits [7:1] equal `own_addr[7:1]`. Bit 0 is not compared. A mismatching byte leaves `addr_hit` unchanged.
- R3: An address byte of 0x00 sets `gcall` in both addressing widths. With `ten_bit`=0 it also sets `addr_hit`. With `ten_bit`=1 it sets `addr_hit` only when `own_addr` is 0x00.
- R4: With `ten_bit`=1, an address byte sets `addr_hit` only when all 8 bits equal `own_addr`, bit 0 included.
- R5: A pulse on `start_det` or `stop_det` clears `gcall`. A pulse on `dsr_wr` does not clear `gcall`.
- R6: A pulse on `dsr_wr` clears `addr_hit`. Pulses on `start_det` and `stop_det` do not clear `addr_hit`.
- R7: A byte counts as an address byte only when `rx_valid`, `first_byte` and `slave_rx` are all 1 in the same cycle. Any other byte leaves all three outputs unchanged.
- R8: `rw_bit` takes bit 0 of each address byte and holds that value until the next address byte arrives.
- R9: All outputs update on the clock edge that samples the strobe. When a set and a clear of the same flag fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_rx | input | 1 | Interface is in slave receive mode |
| rx_byte | input | 8 | Byte delivered by the shifter |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is valid |
| first_byte | input | 1 | The current byte is the first one after a START |
| own_addr | input | 8 | Own-address register |
| ten_bit | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| start_det | input | 1 | START or repeated START detected (pulse) |
| stop_det | input | 1 | STOP detected (pulse) |
| dsr_wr | input | 1 | CPU write to the data shift register (pulse) |
| addr_hit | output | 1 | Own address (or general call in 7-bit mode) matched |
| gcall | output | 1 | General call received |
| rw_bit | output | 1 | Read/write bit of the last address byte |

## Verification
Two coincidences matter here. In the first, a matching address byte arrives in the same cycle as a CPU write to the data shift register, so the set and the clear of `addr_hit` collide. In the second, a general-call byte arrives together with a START pulse, so the set and the clear of `gcall` collide. The bench drives both inputs of each pair in one cycle and expects the flag to be 1 on the next edge. It then drives the clearing pulse alone and expects the flag to drop. This shows that the flag was really set by the collision and not left over from earlier.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slave_rx,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_valid,
  input  logic         first_byte,
  input  logic [W-1:0] own_addr,
  input  logic         ten_bit,
  input  logic         start_det,
  input  logic         stop_det,
  input  logic         dsr_wr,
  output logic         addr_hit,
  output logic         gcall,
  output logic         rw_bit
);
  logic is_addr, is_gc, hit7, hit10, set_hit, set_gc;

  assign is_addr = rx_valid & first_byte & slave_rx;
  assign is_gc   = (rx_byte == '0);
  assign hit7    = (rx_byte[W-1:1] == own_addr[W-1:1]) | is_gc;
  assign hit10   = (rx_byte == own_addr);
  assign set_hit = is_addr & (ten_bit ? hit10 : hit7);
  assign set_gc  = is_addr & is_gc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hit <= 1'b0;
      gcall    <= 1'b0;
      rw_bit   <= 1'b0;
    end else begin
      if (set_hit)     addr_hit <= 1'b1;
      else if (dsr_wr) addr_hit <= 1'b0;
      if (set_gc)                      gcall <= 1'b1;
      else if (start_det || stop_det)  gcall <= 1'b0;
      if (is_addr) rw_bit <= rx_byte[0];
    end
  end
endmodule

module i2c_addr_match_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         slave_rx,
  input logic [W-1:0] rx_byte,
  input logic         rx_valid,
  input logic         first_byte,
  input logic [W-1:0] own_addr,
  input logic         ten_bit,
  input logic         start_det,
  input logic         stop_det,
  input logic         dsr_wr,
  input logic         addr_hit,
  input logic         gcall,
  input logic         rw_bit
);
  logic addr_now;
  assign addr_now = rx_valid && first_byte && slave_rx;

  a_r2_match7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_now && !ten_bit && rx_byte[W-1:1] == own_addr[W-1:1]) |=> addr_hit);

  a_r3_gcall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_now && rx_byte == '0) |=> gcall);

  a_r4_match10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_now && ten_bit && rx_byte == own_addr) |=> addr_hit);

  a_r5_gcall_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_det || stop_det) && !(addr_now && rx_byte == '0)) |=> !gcall);

  a_r6_hit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dsr_wr && !addr_now) |=> !addr_hit);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_now && !dsr_wr && !start_det && !stop_det) |=>
      ($stable(addr_hit) && $stable(gcall)));

  a_r8_rw: assert property (@(posedge clk) disable iff (!rst_n)
    addr_now |=> (rw_bit == $past(rx_byte[0])));

  a_r8_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_now |=> $stable(rw_bit));
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_rx(slave_rx), .rx_byte(rx_byte),
  .rx_valid(rx_valid), .first_byte(first_byte), .own_addr(own_addr),
  .ten_bit(ten_bit), .start_det(start_det), .stop_det(stop_det),
  .dsr_wr(dsr_wr), .addr_hit(addr_hit), .gcall(gcall), .rw_bit(rw_bit)
);

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;
  logic clk = 0, rst_n = 0;
  logic slave_rx = 0, rx_valid = 0, first_byte = 0, ten_bit = 0;
  logic start_det = 0, stop_det = 0, dsr_wr = 0;
  logic [7:0] rx_byte = 0, own_addr = 0;
  logic addr_hit, gcall, rw_bit;

  always #4 clk = ~clk;

  i2c_addr_match u0 (.*);

  typedef struct { logic aas; logic ad0; logic rw; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic m_aas = 0, m_ad0 = 0, m_rw = 0;
  bit done = 0;

  task automatic op(input logic srx, input logic vld, input logic fb,
                    input logic tb, input logic st, input logic sp,
                    input logic wr, input logic [7:0] b,
                    input logic [7:0] own, input string tag);
    logic cmp, gc, sa;
    exp_t e;
    @(negedge clk);
    slave_rx = srx; rx_valid = vld; first_byte = fb; ten_bit = tb;
    start_det = st; stop_det = sp; dsr_wr = wr; rx_byte = b; own_addr = own;
    cmp = srx & vld & fb;
    gc  = (b == 8'h00);
    sa  = cmp & (tb ? (b == own) : ((b[7:1] == own[7:1]) | gc));
    if (sa) m_aas = 1; else if (wr) m_aas = 0;
    if (cmp & gc) m_ad0 = 1; else if (st | sp) m_ad0 = 0;
    if (cmp) m_rw = b[0];
    e.aas = m_aas; e.ad0 = m_ad0; e.rw = m_rw; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic addr(input logic tb, input logic [7:0] b,
                      input logic [7:0] own, input string tag);
    op(1, 1, 1, tb, 0, 0, 0, b, own, tag);
  endtask

  task automatic idle(input string tag);
    op(1, 0, 0, ten_bit, 0, 0, 0, 8'h00, own_addr, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (addr_hit !== e.aas || gcall !== e.ad0 || rw_bit !== e.rw) begin
        fails++;
        $display("FAIL %s: got aas=%b ad0=%b rw=%b expected aas=%b ad0=%b rw=%b",
                 e.tag, addr_hit, gcall, rw_bit, e.aas, e.ad0, e.rw);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (addr_hit !== 0 || gcall !== 0 || rw_bit !== 0) begin
      fails++;
      $display("FAIL R1 reset: got %b%b%b expected 000", addr_hit, gcall, rw_bit);
    end
    @(negedge clk); rst_n = 1;

    addr(0, 8'hA5, 8'hA4, "R2 7-bit match bit0 ignored, R8 rw=1");
    op(1, 0, 0, 0, 0, 0, 1, 8'h00, 8'hA4, "R6 dsr write clears hit");
    addr(0, 8'hA6, 8'hA4, "R2 mismatch, R8 rw=0");
    op(1, 1, 0, 0, 0, 0, 0, 8'hA5, 8'hA4, "R7 not first byte");
    op(0, 1, 1, 0, 0, 0, 0, 8'hA5, 8'hA4, "R7 not slave rx");
    addr(0, 8'h00, 8'hA4, "R3 general call 7-bit");
    op(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'hA4, "R5 start clears gcall, R6 hit kept");
    op(1, 0, 0, 0, 0, 1, 0, 8'h00, 8'hA4, "R6 stop keeps hit");
    op(1, 0, 0, 0, 0, 0, 1, 8'h00, 8'hA4, "R6 dsr write clears hit");
    addr(0, 8'h00, 8'hA4, "R3 general call again");
    op(1, 0, 0, 0, 0, 0, 1, 8'h00, 8'hA4, "R5 dsr write keeps gcall");
    op(1, 0, 0, 0, 0, 1, 0, 8'h00, 8'hA4, "R5 stop clears gcall");
    addr(1, 8'hF3, 8'hF2, "R4 10-bit bit0 differs");
    idle("R8 rw held");
    addr(1, 8'hF2, 8'hF2, "R4 10-bit full match");
    op(1, 0, 0, 1, 0, 0, 1, 8'h00, 8'hF2, "R6 clear");
    addr(1, 8'h00, 8'hF2, "R3 general call 10-bit no hit");
    op(1, 0, 0, 1, 0, 1, 0, 8'h00, 8'hF2, "R5 stop");
    addr(1, 8'h00, 8'h00, "R3 10-bit own 0x00 hit");
    op(1, 0, 0, 1, 1, 0, 1, 8'h00, 8'h00, "R5 R6 start and dsr clear");
    op(1, 1, 1, 0, 0, 0, 1, 8'hA4, 8'hA4, "R9 hit set beats dsr clear");
    op(1, 1, 1, 0, 1, 0, 0, 8'h00, 8'hA4, "R9 gcall set beats start clear");
    op(1, 0, 0, 0, 1, 0, 1, 8'h00, 8'hA4, "R9 follow-up clears both");
    op(1, 1, 0, 0, 0, 0, 0, 8'h00, 8'hA4, "R7 zero byte not first");
    idle("R8 idle");
    idle("R8 idle");

    @(posedge clk); #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule